// File: doc/BRIEF.md
# Exception Vector and Fault Capture Register Bank

This block is a bank of special registers that a 32-bit processor core consults when it takes an exception. It holds one shared handler-address prefix, sixteen per-type handler offsets, a register that records the data address behind a data-side fault, and a register that preserves the machine state word across a machine-check interrupt. Software moves values to and from any register by number through a single move-to/move-from port. The read path is combinational and the write takes effect on the next clock edge.

When the core dispatches an interrupt, it presents a 4-bit interrupt type. The block returns the handler entry address at once. The upper half of that address comes from the prefix register. The next twelve bits come from the offset register of that type. The low nibble is always zero, so every entry point is 16-byte aligned.

Hardware events update the two capture registers directly. A data-side exception (alignment, data TLB miss or data storage) loads the faulting address. Taking a machine check saves the current machine state word. A return-from-machine-check strobe presents the saved word so that it can become the new machine state. All 32 bits come back, reserved ones included. Interrupt priority, pipeline flushing, translation and the remaining machine state logic live elsewhere.

Top module: `exc_vector_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared, so every readable number returns zero and `vec_addr` is zero.
- R2: Register numbers 0 to 15 are the sixteen offset registers, each independent. A write keeps only bits [15:4] of `sw_wdata`. A read returns those bits in place, with bits [31:16] and [3:0] reading as zero.
- R3: Register number 16 is the prefix register. A write keeps only bits [31:16]. A read returns them in place, with bits [15:0] reading as zero.
- R4: `vec_addr` is combinational and equals {prefix[31:16], offset[int_type][15:4], 4'b0000}.
- R5: When `dfault_valid` is high at a clock edge, the fault address register (number 17) loads `dfault_addr`.
- R6: When `mchk_take` is high at a clock edge, the machine-check save register (number 18) loads all 32 bits of `msr_in`.
- R7: `msr_restore` always shows the full 32-bit machine-check save register, reserved bits included. `msr_restore_valid` follows `mchk_return` combinationally.
- R8: If a hardware capture (R5 or R6) and a software write target the same register in the same cycle, the register takes the hardware value.
- R9: Register numbers 19 to 31 are unimplemented. They read as zero, and writing them changes no register.
- R10: Registers 17 and 18 can be written with any 32-bit value by software when no hardware capture hits them in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_num | input | 5 | Register number for the read and the write |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Combinational read data of register `sw_num` |
| int_type | input | 4 | Interrupt type selecting an offset register |
| vec_addr | output | 32 | Handler entry address |
| dfault_valid | input | 1 | Data-side exception capture strobe |
| dfault_addr | input | 32 | Address referenced by the faulting access |
| mchk_take | input | 1 | Machine-check interrupt taken |
| msr_in | input | 32 | Current machine state word |
| mchk_return | input | 1 | Return-from-machine-check strobe |
| msr_restore | output | 32 | Saved machine state word to restore |
| msr_restore_valid | output | 1 | Restore value is to be applied |

## Verification
The bench writes all-ones and alternating patterns so that a design storing the wrong field shows stray bits in the read-back or in the handler address. It sweeps every interrupt type after loading distinct offsets, which exposes a mis-indexed or off-by-one offset select. It collides software writes with fault and machine-check captures, where the wrong priority would leave the software value in place. It also writes every unimplemented number and then reads back the whole bank, so that an aliased decode would corrupt a real register.

// File: rtl/exc_vec_pkg.sv
// Package: shared sizes and register numbers of the exception register bank.
// Assumes big-endian field bounds have already been mapped to [31:0] indices.
package exc_vec_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned NUM_W     = 5;
    localparam int unsigned N_OFS     = 16;
    localparam int unsigned OFS_LSB   = 4;
    localparam int unsigned OFS_MSB   = 15;
    localparam int unsigned PFX_LSB   = 16;
    localparam int unsigned REG_PFX   = 16;
    localparam int unsigned REG_FAULT = 17;
    localparam int unsigned REG_MCSV  = 18;
endpackage

// File: rtl/exc_offset_bank.sv
// Module: sixteen handler offset registers, each storing only its aligned field.
// Provides one software read port and one interrupt-type select port.
// Assumes wr_idx is valid only while wr_en is high.
module exc_offset_bank #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned N_OFS   = 16,
    parameter int unsigned OFS_LSB = 4,
    parameter int unsigned OFS_MSB = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(N_OFS)-1:0]  wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [$clog2(N_OFS)-1:0]  rd_idx,
    output logic [XLEN-1:0]           rd_data,
    input  logic [$clog2(N_OFS)-1:0]  sel_idx,
    output logic [XLEN-1:0]           sel_ofs
);
    localparam int unsigned IDX_W = $clog2(N_OFS);
    localparam int unsigned OFS_W = OFS_MSB - OFS_LSB + 1;

    logic [OFS_W-1:0] ofs_q [N_OFS];

    for (genvar k = 0; k < N_OFS; k++) begin : g_ofs
        // Holds one offset field; loaded on a matching software write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ofs_q[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))
                ofs_q[k] <= wr_data[OFS_MSB:OFS_LSB];
        end

        AST_OFS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(k)) |=> (ofs_q[k] == $past(wr_data[OFS_MSB:OFS_LSB]))); // R2
    end

    // Software read path: field placed in position, all other bits zero.
    always_comb begin
        rd_data = '0;
        rd_data[OFS_MSB:OFS_LSB] = ofs_q[rd_idx];
    end

    // Interrupt select path: same placement for the handler address.
    always_comb begin
        sel_ofs = '0;
        sel_ofs[OFS_MSB:OFS_LSB] = ofs_q[sel_idx];
    end
endmodule

// File: rtl/exc_capture_reg.sv
// Module: full-width register written by software or captured by a hardware event.
// The hardware capture takes precedence when both occur in one cycle.
module exc_capture_reg #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_data,
    input  logic            hw_we,
    input  logic [XLEN-1:0] hw_data,
    output logic [XLEN-1:0] q
);
    // Storage with hardware-over-software priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (hw_we)
            q <= hw_data;
        else if (sw_we)
            q <= sw_data;
    end

    AST_HW_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we |=> (q == $past(hw_data))); // R8
    AST_SW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !hw_we) |=> (q == $past(sw_data))); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !hw_we) |=> $stable(q)); // R9
endmodule

// File: rtl/exc_vector_regs.sv
// Module: top of the exception register bank. It decodes the move-to/move-from
// register number, holds the vector prefix, builds the handler address and
// drives the machine-check restore word. Reset is synchronous, active-low.
module exc_vector_regs
    import exc_vec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [NUM_W-1:0] sw_num,
    input  logic [XLEN-1:0]  sw_wdata,
    output logic [XLEN-1:0]  sw_rdata,
    input  logic [3:0]       int_type,
    output logic [XLEN-1:0]  vec_addr,
    input  logic             dfault_valid,
    input  logic [XLEN-1:0]  dfault_addr,
    input  logic             mchk_take,
    input  logic [XLEN-1:0]  msr_in,
    input  logic             mchk_return,
    output logic [XLEN-1:0]  msr_restore,
    output logic             msr_restore_valid
);
    localparam int unsigned IDX_W = $clog2(N_OFS);
    localparam int unsigned PFX_W = XLEN - PFX_LSB;

    logic            ofs_hit, pfx_hit, fault_hit, mcsv_hit;
    logic [XLEN-1:0] ofs_rd, ofs_sel, fault_q, mcsv_q;
    logic [PFX_W-1:0] pfx_q;

    // Register-number decode for writes and reads.
    always_comb begin
        ofs_hit   = (sw_num < NUM_W'(N_OFS));
        pfx_hit   = (sw_num == NUM_W'(REG_PFX));
        fault_hit = (sw_num == NUM_W'(REG_FAULT));
        mcsv_hit  = (sw_num == NUM_W'(REG_MCSV));
    end

    exc_offset_bank #(
        .XLEN(XLEN), .N_OFS(N_OFS), .OFS_LSB(OFS_LSB), .OFS_MSB(OFS_MSB)
    ) u_ofs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sw_we && ofs_hit),
        .wr_idx  (sw_num[IDX_W-1:0]),
        .wr_data (sw_wdata),
        .rd_idx  (sw_num[IDX_W-1:0]),
        .rd_data (ofs_rd),
        .sel_idx (int_type[IDX_W-1:0]),
        .sel_ofs (ofs_sel)
    );

    // Prefix register: keeps only the upper half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pfx_q <= '0;
        else if (sw_we && pfx_hit)
            pfx_q <= sw_wdata[XLEN-1:PFX_LSB];
    end

    exc_capture_reg #(.XLEN(XLEN)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (sw_we && fault_hit),
        .sw_data (sw_wdata),
        .hw_we   (dfault_valid),
        .hw_data (dfault_addr),
        .q       (fault_q)
    );

    exc_capture_reg #(.XLEN(XLEN)) u_mcsv (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (sw_we && mcsv_hit),
        .sw_data (sw_wdata),
        .hw_we   (mchk_take),
        .hw_data (msr_in),
        .q       (mcsv_q)
    );

    // Read mux: unimplemented numbers return zero.
    always_comb begin
        if (ofs_hit)        sw_rdata = ofs_rd;
        else if (pfx_hit)   sw_rdata = {pfx_q, {PFX_LSB{1'b0}}};
        else if (fault_hit) sw_rdata = fault_q;
        else if (mcsv_hit)  sw_rdata = mcsv_q;
        else                sw_rdata = '0;
    end

    // Handler address: prefix high half joined with the selected aligned offset.
    always_comb begin
        vec_addr = {pfx_q, ofs_sel[PFX_LSB-1:0]};
    end

    // Restore path toward the machine state logic.
    always_comb begin
        msr_restore       = mcsv_q;
        msr_restore_valid = mchk_return;
    end

    AST_PFX_REACHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && pfx_hit) |=> (vec_addr[XLEN-1:PFX_LSB] == $past(sw_wdata[XLEN-1:PFX_LSB]))); // R4
    AST_RESTORE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_take |=> (msr_restore == $past(msr_in))); // R7
    AST_FAULT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dfault_valid && $stable(sw_num) && sw_num == NUM_W'(REG_FAULT)) |=> (sw_rdata == $past(dfault_addr))); // R5
endmodule

// File: tb/exc_vector_regs_tb.sv
`timescale 1ns/1ps
module exc_vector_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [4:0]  sw_num = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic [3:0]  int_type = '0;
    logic [31:0] vec_addr;
    logic        dfault_valid = 1'b0;
    logic [31:0] dfault_addr = '0;
    logic        mchk_take = 1'b0;
    logic [31:0] msr_in = '0;
    logic        mchk_return = 1'b0;
    logic [31:0] msr_restore;
    logic        msr_restore_valid;

    int n_vec = 0;
    int n_bad = 0;

    // Behavioural reference state.
    logic [31:0] m_ofs [16];
    logic [31:0] m_pfx = '0, m_fault = '0, m_mcsv = '0;

    always #10 clk = ~clk;

    exc_vector_regs dut_i (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_num(sw_num),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .int_type(int_type),
        .vec_addr(vec_addr), .dfault_valid(dfault_valid), .dfault_addr(dfault_addr),
        .mchk_take(mchk_take), .msr_in(msr_in), .mchk_return(mchk_return),
        .msr_restore(msr_restore), .msr_restore_valid(msr_restore_valid)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] n);
        if (n < 16)       return m_ofs[n[3:0]];
        else if (n == 16) return m_pfx;
        else if (n == 17) return m_fault;
        else if (n == 18) return m_mcsv;
        else              return 32'h0;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare outputs, then advance the model at posedge.
    task automatic step(input string tag, input logic rn, input logic we, input logic [4:0] num,
                        input logic [31:0] wd, input logic [3:0] it,
                        input logic df, input logic [31:0] da,
                        input logic mt, input logic [31:0] mi, input logic mr);
        @(negedge clk);
        rst_n = rn; sw_we = we; sw_num = num; sw_wdata = wd; int_type = it;
        dfault_valid = df; dfault_addr = da; mchk_take = mt; msr_in = mi; mchk_return = mr;
        #1;
        cmp(tag, "rdata", sw_rdata, exp_read(num));
        cmp(tag, "vec", vec_addr, m_pfx | m_ofs[it]);
        cmp(tag, "restore", msr_restore, m_mcsv);
        cmp(tag, "restore_valid", {31'b0, msr_restore_valid}, {31'b0, mr});
        @(posedge clk);
        if (!rn) begin
            for (int i = 0; i < 16; i++) m_ofs[i] = '0;
            m_pfx = '0; m_fault = '0; m_mcsv = '0;
        end else begin
            if (we) begin
                if (num < 16)       m_ofs[num[3:0]] = wd & 32'h0000_FFF0;
                else if (num == 16) m_pfx = wd & 32'hFFFF_0000;
                else if (num == 17) m_fault = wd;
                else if (num == 18) m_mcsv = wd;
            end
            if (df) m_fault = da;
            if (mt) m_mcsv = mi;
        end
    endtask

    task automatic wr(input string tag, input logic [4:0] num, input logic [31:0] wd);
        step(tag, 1'b1, 1'b1, num, wd, 4'd0, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic rd(input string tag, input logic [4:0] num, input logic [3:0] it);
        step(tag, 1'b1, 1'b0, num, '0, it, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_ofs[i] = '0;
        repeat (2) @(posedge clk);
        // R1: reset clears, checked on every number while reset is held.
        for (int n = 0; n < 32; n++)
            step("R1", 1'b0, 1'b0, 5'(n), '0, 4'(n), 1'b0, '0, 1'b0, '0, 1'b0);
        // R2: all-ones then distinct patterns in every offset register.
        for (int n = 0; n < 16; n++) wr("R2", 5'(n), 32'hFFFF_FFFF);
        for (int n = 0; n < 16; n++) rd("R2", 5'(n), 4'(n));
        for (int n = 0; n < 16; n++) wr("R2", 5'(n), 32'hA5A5_0000 | (32'(n) * 32'h0000_1111));
        // R3: prefix keeps only the upper half.
        wr("R3", 5'd16, 32'hFFFF_FFFF);
        rd("R3", 5'd16, 4'd0);
        wr("R3", 5'd16, 32'h1234_5678);
        // R4: handler address for every type.
        for (int t = 0; t < 16; t++) rd("R4", 5'd16, 4'(t));
        wr("R4", 5'd3, 32'h0000_ABCF);
        rd("R4", 5'd3, 4'd3);
        // R5: data fault capture.
        step("R5", 1'b1, 1'b0, 5'd17, '0, 4'd0, 1'b1, 32'hDEAD_BEEF, 1'b0, '0, 1'b0);
        rd("R5", 5'd17, 4'd0);
        step("R5", 1'b1, 1'b0, 5'd17, '0, 4'd1, 1'b1, 32'h0000_0003, 1'b0, '0, 1'b0);
        rd("R5", 5'd17, 4'd0);
        // R6: machine-check save of all bits.
        step("R6", 1'b1, 1'b0, 5'd18, '0, 4'd0, 1'b0, '0, 1'b1, 32'hFFFF_FFFF, 1'b0);
        rd("R6", 5'd18, 4'd0);
        step("R6", 1'b1, 1'b0, 5'd18, '0, 4'd0, 1'b0, '0, 1'b1, 32'h8002_9A01, 1'b0);
        // R7: restore strobe presents the saved word.
        step("R7", 1'b1, 1'b0, 5'd18, '0, 4'd0, 1'b0, '0, 1'b0, '0, 1'b1);
        step("R7", 1'b1, 1'b0, 5'd18, '0, 4'd0, 1'b0, '0, 1'b0, '0, 1'b0);
        // R8: capture beats a same-cycle software write.
        step("R8", 1'b1, 1'b1, 5'd17, 32'h1111_1111, 4'd0, 1'b1, 32'h2222_2222, 1'b0, '0, 1'b0);
        rd("R8", 5'd17, 4'd0);
        step("R8", 1'b1, 1'b1, 5'd18, 32'h3333_3333, 4'd0, 1'b0, '0, 1'b1, 32'h4444_4444, 1'b0);
        rd("R8", 5'd18, 4'd0);
        // R10: software writes to the capture registers.
        wr("R10", 5'd17, 32'hCAFE_F00D);
        rd("R10", 5'd17, 4'd0);
        wr("R10", 5'd18, 32'h0F0F_F0F0);
        step("R10", 1'b1, 1'b0, 5'd18, '0, 4'd0, 1'b0, '0, 1'b0, '0, 1'b1);
        // R9: unimplemented numbers read zero and writes change nothing.
        for (int n = 19; n < 32; n++) wr("R9", 5'(n), 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) rd("R9", 5'(n), 4'(n));
        // R1: reset again after traffic.
        step("R1", 1'b0, 1'b0, 5'd16, '0, 4'd5, 1'b0, '0, 1'b0, '0, 1'b0);
        for (int n = 0; n < 19; n++) rd("R1", 5'(n), 4'(n));
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule